// File: doc/BRIEF.md
# Three-Channel Timer Interrupt and Conversion Trigger Unit

This block keeps the sticky status flags and the enable bits of a three-channel timer. It turns them into one interrupt request per source and into a start pulse for an analog-to-digital converter. The timer channels feed it one-cycle event pulses: a compare/capture match for each general register, a counter overflow and a counter underflow. Software reaches the block through a small register port. The port reads flags, clears them by writing zeros, and reads or writes the enable bits.

The sources are not spread evenly over the channels. Channel 0 has four match sources (A to D). Channels 1 and 2 have two each (A and B). Every channel has an overflow source, but only channels 1 and 2 have an underflow source. The A match flag of each channel also acts as a converter-start source. A start is raised only when the channel's trigger enable is set, and it reaches the converter only while the converter reports that it has selected the timer as its trigger.

The register port has no valid/ready handshake: it accepts a write in every cycle and answers reads combinationally, so it never applies back-pressure. Event inputs and the converter-select input are plain level or pulse signals.

Top module: `tmr_evt_ctl`

## Requirements
- R1: A one-cycle pulse on an event input sets its status flag at the next clock edge. The flag then stays 1 until software clears it.
- R2: A register write to a channel's flag register at address 2*c clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 untouched. If an event and a clearing write hit the same flag in the same cycle, the flag stays 1.
- R3: The interrupt line of each source is 1 exactly while its flag and its enable are both 1. A line falls only after a register write.
- R4: Flag and enable bits 0..3 hold match sources A..D. Channel 0 implements bits 0..3 and channels 1 and 2 implement bits 0..1. Bits that are not implemented read 0. Output irq_cmp maps channel 0 A..D to bits 0..3, channel 1 A,B to bits 4,5 and channel 2 A,B to bits 6,7.
- R5: Bit 4 of each channel's flag and enable registers is the overflow source. irq_ovf[c] belongs to channel c.
- R6: Bit 5 is the underflow source and exists only on channels 1 and 2, which drive irq_udf[0] and irq_udf[1]. On channel 0, bit 5 reads 0.
- R7: The enable register of channel c is at address 2*c+1. It reads back what was written, restricted to the implemented source bits plus bit 6, which is the channel's trigger enable.
- R8: When a channel's A flag goes from 0 to 1 while its trigger enable is 1, conv_start is 1 for exactly the one cycle in which the flag first reads 1. An A event that arrives while the flag is already 1 makes no pulse.
- R9: conv_start stays 0 if adc_sel_tmr was 0 at the edge where the A flag was set. The flag itself is still set.
- R10: Start requests from several channels at the same edge merge into a single one-cycle conv_start pulse.
- R11: After reset, all flags and enables are 0, and all interrupt lines and conv_start are 0.
- R12: Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (flags at 2*c, enables at 2*c+1) |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Register read data for reg_addr |
| ev_cmp | input | 8 | Match event pulses, same bit order as irq_cmp |
| ev_ovf | input | 3 | Overflow event pulse per channel |
| ev_udf | input | 2 | Underflow event pulses of channels 1 and 2 |
| adc_sel_tmr | input | 1 | Converter has selected the timer as trigger |
| irq_cmp | output | 8 | Match interrupt requests |
| irq_ovf | output | 3 | Overflow interrupt requests |
| irq_udf | output | 2 | Underflow interrupt requests of channels 1 and 2 |
| conv_start | output | 1 | One-cycle converter start pulse |

## Verification
Each interrupt line is a plain AND of two stored bits. A flag that is lost, stuck or routed to the wrong source therefore shows up on the interrupt outputs in the cycle right after the event or write, and it shows up again on the flag register readback. A wrong A-flag history or a wrong trigger-enable bit shows up only through conv_start, one cycle after the event edge. For that reason the bench samples that output in the first cycle after each A event and again in the cycle after that. Missing bits and stray bits in the source layout are exposed by sweeping every enable pattern through each channel and by pulsing every event input one at a time.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NCH     = 3;
  localparam int MAXCMP  = 4;
  localparam int NSRC    = 6;
  localparam int OVF_BIT = 4;
  localparam int UDF_BIT = 5;
  localparam int TRG_BIT = NSRC;
  localparam int RW      = NSRC + 1;

  function automatic int cmp_cnt(input int ch);
    return (ch == 0) ? 4 : 2;
  endfunction

  function automatic bit udf_has(input int ch);
    return ch != 0;
  endfunction

  function automatic int cmp_base(input int ch);
    int acc;
    acc = 0;
    for (int i = 0; i < ch; i++) acc += cmp_cnt(i);
    return acc;
  endfunction

  function automatic int udf_base(input int ch);
    int acc;
    acc = 0;
    for (int i = 0; i < ch; i++) acc += udf_has(i) ? 1 : 0;
    return acc;
  endfunction

  localparam int NCMP_TOT = cmp_base(NCH);
  localparam int NUDF_TOT = udf_base(NCH);
endpackage

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan
  import tmr_evt_pkg::*;
#(
  parameter int NCMP    = 4,
  parameter bit HAS_UDF = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_i,
  input  logic            wr_flag_i,
  input  logic            wr_ena_i,
  input  logic [RW-1:0]   wdata_i,
  output logic [NSRC-1:0] flag_o,
  output logic [RW-1:0]   ena_o,
  output logic            start_hit_o
);
  localparam logic [NSRC-1:0] CMP_M = NSRC'((32'd1 << NCMP) - 32'd1);
  localparam logic [NSRC-1:0] OVF_M = NSRC'(32'd1 << OVF_BIT);
  localparam logic [NSRC-1:0] UDF_M = HAS_UDF ? NSRC'(32'd1 << UDF_BIT) : '0;
  localparam logic [NSRC-1:0] IMPL  = CMP_M | OVF_M | UDF_M;

  logic [NSRC-1:0] flag_q, flag_d, clr_m, ena_q;
  logic            trg_q;

  always_comb begin
    clr_m  = wr_flag_i ? ~wdata_i[NSRC-1:0] : '0;
    flag_d = ((flag_q & ~clr_m) | ev_i) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      ena_q  <= '0;
      trg_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_ena_i) begin
        ena_q <= wdata_i[NSRC-1:0] & IMPL;
        trg_q <= wdata_i[TRG_BIT];
      end
    end
  end

  // A rising A flag with trigger enabled; the flag must read 0 before the edge.
  assign start_hit_o = ev_i[0] & ~flag_q[0] & trg_q;
  assign flag_o      = flag_q;
  assign ena_o       = {trg_q, ena_q};

  p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_i & IMPL)) |=> ((flag_q & $past(ev_i & IMPL)) == $past(ev_i & IMPL)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_hit_sets_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit_o |=> flag_q[0]);

  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q | ena_q) & ~IMPL) == '0);
endmodule

// File: rtl/tmr_evt_start.sv
module tmr_evt_start #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic         sel_i,
  output logic         conv_start_o
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= (|hit_i) & sel_i;
  end

  assign conv_start_o = start_q;

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !conv_start_o);

  p_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> ($past(|hit_i) && $past(sel_i)));
endmodule

// File: rtl/tmr_evt_regmux.sv
module tmr_evt_regmux
  import tmr_evt_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic [AW-1:0]              addr_i,
  input  logic [NCH-1:0][NSRC-1:0]   flag_i,
  input  logic [NCH-1:0][RW-1:0]     ena_i,
  output logic [RW-1:0]              rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(2 * c))     rdata_o = {1'b0, flag_i[c]};
      if (addr_i == AW'(2 * c + 1)) rdata_o = ena_i[c];
    end
  end
endmodule

// File: rtl/tmr_evt_ctl.sv
module tmr_evt_ctl
  import tmr_evt_pkg::*;
#(
  parameter int AW = $clog2(2 * NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [RW-1:0]       reg_wdata,
  output logic [RW-1:0]       reg_rdata,
  input  logic [NCMP_TOT-1:0] ev_cmp,
  input  logic [NCH-1:0]      ev_ovf,
  input  logic [NUDF_TOT-1:0] ev_udf,
  input  logic                adc_sel_tmr,
  output logic [NCMP_TOT-1:0] irq_cmp,
  output logic [NCH-1:0]      irq_ovf,
  output logic [NUDF_TOT-1:0] irq_udf,
  output logic                conv_start
);
  logic [NCH-1:0][NSRC-1:0] ev_vec, flags;
  logic [NCH-1:0][RW-1:0]   enas;
  logic [NCH-1:0]           hits;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int NC = cmp_cnt(c);
    localparam int CB = cmp_base(c);

    for (genvar k = 0; k < MAXCMP; k++) begin : g_cmp
      if (k < NC) begin : g_on
        assign ev_vec[c][k]            = ev_cmp[CB + k];
        assign irq_cmp[CB + k]         = flags[c][k] & enas[c][k];
      end else begin : g_off
        assign ev_vec[c][k]            = 1'b0;
      end
    end

    assign ev_vec[c][OVF_BIT] = ev_ovf[c];
    assign irq_ovf[c]         = flags[c][OVF_BIT] & enas[c][OVF_BIT];

    if (udf_has(c)) begin : g_udf
      localparam int UB = udf_base(c);
      assign ev_vec[c][UDF_BIT] = ev_udf[UB];
      assign irq_udf[UB]        = flags[c][UDF_BIT] & enas[c][UDF_BIT];
    end else begin : g_noudf
      assign ev_vec[c][UDF_BIT] = 1'b0;
    end

    tmr_evt_chan #(
      .NCMP    (NC),
      .HAS_UDF (udf_has(c))
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_i        (ev_vec[c]),
      .wr_flag_i   (reg_we && (reg_addr == AW'(2 * c))),
      .wr_ena_i    (reg_we && (reg_addr == AW'(2 * c + 1))),
      .wdata_i     (reg_wdata),
      .flag_o      (flags[c]),
      .ena_o       (enas[c]),
      .start_hit_o (hits[c])
    );
  end

  tmr_evt_regmux #(.AW(AW)) u_mux (
    .addr_i  (reg_addr),
    .flag_i  (flags),
    .ena_i   (enas),
    .rdata_o (reg_rdata)
  );

  tmr_evt_start #(.N(NCH)) u_start (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (hits),
    .sel_i        (adc_sel_tmr),
    .conv_start_o (conv_start)
  );

  logic [NCMP_TOT+NCH+NUDF_TOT-1:0] irq_all;
  assign irq_all = {irq_udf, irq_ovf, irq_cmp};

  p_irq_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((irq_all & $past(irq_all)) == $past(irq_all)));

  p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_all == '0 && !conv_start));
endmodule

// File: tb/tmr_evt_ctl_test.sv
`timescale 1ns/1ps
module tmr_evt_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [6:0] reg_wdata = '0;
  logic [6:0] reg_rdata;
  logic [12:0] ev_all = '0;
  logic       adc_sel_tmr = 1'b0;
  logic [7:0] irq_cmp;
  logic [2:0] irq_ovf;
  logic [1:0] irq_udf;
  logic       conv_start;
  logic [12:0] irq_all;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_evt_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_cmp(ev_all[7:0]), .ev_ovf(ev_all[10:8]), .ev_udf(ev_all[12:11]),
    .adc_sel_tmr(adc_sel_tmr), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf),
    .irq_udf(irq_udf), .conv_start(conv_start)
  );
  assign irq_all = {irq_udf, irq_ovf, irq_cmp};

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int fmask(input int ch);
    return ((ch == 0) ? 15 : 3) | 16 | ((ch != 0) ? 32 : 0);
  endfunction

  function automatic int src_ch(input int s);
    if (s < 8)  return (s < 4) ? 0 : ((s < 6) ? 1 : 2);
    if (s < 11) return s - 8;
    return s - 10;
  endfunction

  function automatic int src_bit(input int s);
    if (s < 8)  return (s < 4) ? s : ((s < 6) ? s - 4 : s - 6);
    if (s < 11) return 4;
    return 5;
  endfunction

  function automatic int a_src(input int ch);
    return (ch == 0) ? 0 : ((ch == 1) ? 4 : 6);
  endfunction

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 7'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 3'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [12:0] v);
    ev_all = v;
    @(negedge clk);
    ev_all = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R12: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, d); chk("R11 reset read", d, 0);
    end
    chk("R11 reset irq", int'(irq_all), 0);
    chk("R11 reset conv_start", int'(conv_start), 0);

    // R7 / R4 / R6: enable register sweep
    for (int ch = 0; ch < 3; ch++) begin
      for (int v = 0; v < 128; v++) begin
        wr(2 * ch + 1, v);
        rd(2 * ch + 1, d);
        chk("R7 enable readback", d, v & (fmask(ch) | 64));
      end
    end

    // R12: unmapped addresses
    wr(6, 127); wr(7, 127);
    rd(6, d); chk("R12 addr6", d, 0);
    rd(7, d); chk("R12 addr7", d, 0);
    rd(1, d); chk("R12 no alias ch0", d, 127 & (fmask(0) | 64));

    // R1..R6: every source in turn with all source enables on
    for (int ch = 0; ch < 3; ch++) wr(2 * ch + 1, 63);
    for (int s = 0; s < 13; s++) begin
      int ch, b;
      ch = src_ch(s); b = src_bit(s);
      pulse(13'(1 << s));
      rd(2 * ch, d);
      chk("R1 flag set", d, 1 << b);
      chk("R4 R5 R6 irq mapping", int'(irq_all), 1 << s);
      @(negedge clk);
      rd(2 * ch, d);
      chk("R1 flag sticky", d, 1 << b);
      wr(2 * ch, 127);
      rd(2 * ch, d);
      chk("R2 write one keeps", d, 1 << b);
      wr(2 * ch, 127 & ~(1 << b));
      rd(2 * ch, d);
      chk("R2 write zero clears", d, 0);
      chk("R3 irq drops after clear", int'(irq_all), 0);
    end

    // R2: set beats clear in the same cycle
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 7'd0; ev_all = 13'(1 << 9);
    @(negedge clk);
    reg_we = 1'b0; ev_all = '0;
    rd(2, d); chk("R2 set wins", d, 16);
    chk("R2 set wins irq", int'(irq_ovf), 2);
    wr(2, 0);

    // R3: enable gates the interrupt
    wr(5, 0);
    pulse(13'(1 << 7));
    chk("R3 disabled irq", int'(irq_all), 0);
    wr(5, 2);
    chk("R3 enabled irq", int'(irq_all), 1 << 7);
    wr(5, 0);
    chk("R3 re-disabled irq", int'(irq_all), 0);
    rd(4, d); chk("R3 flag kept", d, 2);
    wr(4, 0);

    // R8 / R9: conversion start per channel
    for (int ch = 0; ch < 3; ch++) begin
      wr(2 * ch + 1, 64);
      adc_sel_tmr = 1'b1;
      pulse(13'(1 << a_src(ch)));
      chk("R8 start pulse", int'(conv_start), 1);
      @(negedge clk);
      chk("R8 start one cycle", int'(conv_start), 0);
      pulse(13'(1 << a_src(ch)));
      chk("R8 no pulse when already set", int'(conv_start), 0);
      reg_we = 1'b1; reg_addr = 3'(2 * ch); reg_wdata = 7'd0;
      ev_all = 13'(1 << a_src(ch));
      @(negedge clk);
      reg_we = 1'b0; ev_all = '0;
      chk("R8 clear+set no pulse", int'(conv_start), 0);
      rd(2 * ch, d); chk("R8 flag held", d, 1);
      wr(2 * ch, 0);
      adc_sel_tmr = 1'b0;
      pulse(13'(1 << a_src(ch)));
      chk("R9 gated off", int'(conv_start), 0);
      rd(2 * ch, d); chk("R9 flag still set", d, 1);
      wr(2 * ch, 0);
      adc_sel_tmr = 1'b1;
      wr(2 * ch + 1, 0);
      pulse(13'(1 << a_src(ch)));
      chk("R8 trigger disabled", int'(conv_start), 0);
      wr(2 * ch, 0);
    end

    // R10: two channels at once give one pulse
    wr(1, 64); wr(5, 64);
    pulse(13'((1 << 0) | (1 << 6)));
    chk("R10 merged pulse", int'(conv_start), 1);
    @(negedge clk);
    chk("R10 single cycle", int'(conv_start), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule